// File: doc/BRIEF.md
# Byte-wide SPI slave with select-driven framing

This block is the slave end of an SPI link. It runs on the system clock and treats the master's serial clock as an ordinary data input. That clock is oversampled, so it must toggle no faster than a quarter of the system clock rate. Each transfer moves one byte in each direction. Bits come in on the data-in line and go out on the data-out line, which has a separate drive-enable output for the pad.

Configuration inputs choose the following:
- the clock idle level;
- the clock phase;
- the bit order;
- whether the output may be driven at all.

A master enable gates the whole block. On the host side there are three things:
- a transmit byte, which is loaded while the slave is idle and reloaded between back-to-back bytes;
- a received-byte register;
- a completion flag, which stays set until the host pulses a clear input.

The active-low select line frames every byte. While select is high the block ignores the serial clock, keeps its bit counter at zero and discards any partly received byte. A master can therefore always bring the slave back into step by raising select. Serial clock, data-in and select each pass through a two-stage synchronizer before their edges are detected in the system clock domain.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `done_o` is 0, `rx_byte_o` is 0 and `miso_oe_o` is 0.
- R2: The edge on which data-in is sampled is set by (cfg_cpol, cfg_cpha):
  - (0,0) and (1,1) sample on the rising edge;
  - (0,1) and (1,0) sample on the falling edge.
  In all four combinations the received byte equals the byte the master sent.
- R3: `miso_o` changes on the clock edge opposite to the sampling edge. In every mode a master that samples on the sampling edge reads back `tx_byte_i` intact.
- R4: With `cfg_lsb_first`=0 the most significant bit travels first, and with 1 the least significant bit travels first. The same order applies to both directions.
- R5: Once the eighth bit of a byte is sampled, `done_o` becomes 1 and `rx_byte_o` holds that byte.
- R6: `done_o` stays 1 until `done_clr_i` is pulsed, and then reads 0 from the following cycle. A completion in the same cycle as a clear wins.
- R7: Several bytes can be sent within one selection. A byte that completes while `done_o` is still 1 overwrites `rx_byte_o`. The transmit byte is reloaded from `tx_byte_i` between bytes, and `rx_byte_o` changes only when a byte completes.
- R8: Raising select in mid-byte discards the partial byte and sets `done_o` to nothing. The next byte after a new selection is received correctly, from its first bit.
- R9: While select is high, clock and data-in activity has no effect and no byte completes.
- R10: `miso_oe_o` is 1 only while the synchronized select is low, `cfg_en`=1 and `cfg_miso_en`=1. Otherwise the pad is released.
- R11: With `cfg_en`=0 no byte is received and `miso_oe_o` stays 0, even while select is low.
- R12: With `cfg_cpha`=0, the first bit of `tx_byte_i` is on `miso_o`, with the drive enabled, within four system clocks of select falling and before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Master enable for the slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| cfg_miso_en | input | 1 | Allows the data-out line to be driven |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the data-out pad |
| tx_byte_i | input | DATA_W | Byte to send |
| rx_byte_o | output | DATA_W | Last completed received byte |
| done_o | output | 1 | Byte-complete flag |
| done_clr_i | input | 1 | Pulse that clears the flag |

## Verification
The main path is swept over all four clock idle-level and phase combinations and both bit orders. Byte patterns include all zeros, all ones, alternating and asymmetric values. Asymmetric bytes separate a reversed bit order from a correct one. The two phases separate a slave that samples on the wrong edge, or shifts one edge too early, from a correct one.

Further runs cover the following cases:
- Back-to-back bytes within one selection, with the transmit byte changed mid-byte. These show the reload between bytes and the overwrite of a pending received byte.
- A select raised after four bits, followed by a full byte. This separates a counter that resets on deselect from one that stays out of step.
- Clock activity with select high, and a full transfer with the enable off. Both show that nothing completes.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE_LOW_LEAD  = 2'b00,
        MODE_IDLE_LOW_TRAIL = 2'b01,
        MODE_IDLE_HI_LEAD   = 2'b10,
        MODE_IDLE_HI_TRAIL  = 2'b11
    } spi_mode_e;

    // Sampling happens on the falling edge when idle level and phase differ.
    function automatic logic samples_on_fall(input logic cpol, input logic cpha);
        spi_mode_e m;
        m = spi_mode_e'({cpol, cpha});
        return (m == MODE_IDLE_LOW_TRAIL) || (m == MODE_IDLE_HI_LEAD);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int N         = 3,
    parameter int STAGES    = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= RST_VAL;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_slave_pkg::*;
#(
    parameter int W  = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          miso_en,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ss_n_s,
    input  logic [W-1:0]  tx_byte,
    output logic          miso_bit,
    output logic          miso_oe,
    output logic          complete,
    output logic [W-1:0]  rx_word,
    output logic [CW-1:0] bit_cnt
);
    typedef struct packed {
        logic [W-1:0]  tx_sr;
        logic [W-1:0]  rx_sr;
        logic [CW-1:0] cnt;
        logic          fresh;
        logic          sck_prev;
    } core_t;

    core_t q, d;
    logic  active, rise, fall, samp, shft;
    logic [W-1:0] rx_next;

    always_comb begin
        d        = q;
        d.sck_prev = sck_s;
        rise     = sck_s & ~q.sck_prev;
        fall     = ~sck_s & q.sck_prev;
        active   = en & ~ss_n_s;
        samp     = active & (samples_on_fall(cpol, cpha) ? fall : rise);
        shft     = active & (samples_on_fall(cpol, cpha) ? rise : fall);
        rx_next  = lsb_first ? {mosi_s, q.rx_sr[W-1:1]} : {q.rx_sr[W-2:0], mosi_s};
        complete = 1'b0;
        if (!active) begin
            d.tx_sr = tx_byte;
            d.rx_sr = '0;
            d.cnt   = '0;
            d.fresh = cpha;
        end else begin
            if (samp) begin
                d.rx_sr = rx_next;
                if (q.cnt == CW'(W-1)) begin
                    d.cnt    = '0;
                    d.fresh  = 1'b1;
                    complete = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            if (shft) begin
                if (q.fresh) begin
                    d.tx_sr = tx_byte;
                    d.fresh = 1'b0;
                end else begin
                    d.tx_sr = lsb_first ? (q.tx_sr >> 1) : (q.tx_sr << 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word  = rx_next;
    assign miso_bit = lsb_first ? q.tx_sr[0] : q.tx_sr[W-1];
    assign miso_oe  = active & miso_en;
    assign bit_cnt  = q.cnt;
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         complete,
    input  logic [W-1:0] rx_word,
    input  logic         clr,
    output logic [W-1:0] rx_byte,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         flag;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (complete) begin
            d.data = rx_word;
            d.flag = 1'b1;
        end else if (clr) begin
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte = q.data;
    assign done    = q.flag;
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_miso_en,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              done_o,
    input  logic              done_clr_i
);
    logic              sck_s, mosi_s, ss_s;
    logic              complete;
    logic [DATA_W-1:0] rx_word;
    logic [CNT_W-1:0]  bit_cnt;

    spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, mosi_i, sck_i}),
        .q     ({ss_s, mosi_s, sck_s})
    );

    spi_shift_core #(.W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .lsb_first (cfg_lsb_first),
        .miso_en   (cfg_miso_en),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .ss_n_s    (ss_s),
        .tx_byte   (tx_byte_i),
        .miso_bit  (miso_o),
        .miso_oe   (miso_oe_o),
        .complete  (complete),
        .rx_word   (rx_word),
        .bit_cnt   (bit_cnt)
    );

    spi_rx_hold #(.W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .complete (complete),
        .rx_word  (rx_word),
        .clr      (done_clr_i),
        .rx_byte  (rx_byte_o),
        .done     (done_o)
    );
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
    parameter int W  = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ss_sync,
    input logic          complete,
    input logic [CW-1:0] bit_cnt,
    input logic          done_o,
    input logic          done_clr_i,
    input logic [W-1:0]  rx_byte_o,
    input logic          miso_oe_o,
    input logic          cfg_miso_en,
    input logic          cfg_en
);
    p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(complete));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !done_clr_i |=> done_o);

    p_done_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_clr_i && !complete |=> !done_o);

    p_rx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(rx_byte_o));

    p_abort_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sync |=> bit_cnt == '0);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sync |-> !complete);

    p_oe_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o |-> !ss_sync && cfg_miso_en);

    p_oe_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !miso_oe_o && !complete);
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.W(DATA_W), .CW(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_sync     (ss_s),
    .complete    (complete),
    .bit_cnt     (bit_cnt),
    .done_o      (done_o),
    .done_clr_i  (done_clr_i),
    .rx_byte_o   (rx_byte_o),
    .miso_oe_o   (miso_oe_o),
    .cfg_miso_en (cfg_miso_en),
    .cfg_en      (cfg_en)
);

// File: tb/spi_byte_slave_tb.sv
module spi_byte_slave_tb;
    localparam int H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_miso_en = 1'b1;
    logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1, clr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic miso, miso_oe, done;
    logic [7:0] rx_byte;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    spi_byte_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_miso_en(cfg_miso_en), .sck_i(sck), .mosi_i(mosi),
        .ss_n_i(ss_n), .miso_o(miso), .miso_oe_o(miso_oe), .tx_byte_i(tx_byte),
        .rx_byte_o(rx_byte), .done_o(done), .done_clr_i(clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1; wclk(1); clr = 1'b0; wclk(1);
    endtask

    task automatic xfer(input logic [7:0] mo, input logic [7:0] next_tx, input int nbits,
                        output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : 7 - i;
            if (!cfg_cpha) begin
                mosi = mo[idx]; wclk(H);
                mi[idx] = miso; sck = ~sck; wclk(H);
                sck = ~sck;
            end else begin
                sck = ~sck; mosi = mo[idx]; wclk(H);
                mi[idx] = miso; sck = ~sck; wclk(H);
            end
            if (i == 3) tx_byte = next_tx;
        end
        wclk(H);
    endtask

    task automatic select(input logic lvl);
        ss_n = lvl; wclk(4);
    endtask

    initial begin
        logic [7:0] got, mo, tx;
        logic [7:0] pats [6];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h17;
        wclk(3);
        chk("R1 done", done, 0); chk("R1 rx", rx_byte, 0); chk("R1 oe", miso_oe, 0);
        rst_n = 1'b1; wclk(3);

        // R2 R3 R4 R5: full sweep of modes, orders and patterns
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int p = 0; p < 6; p++) begin
                    cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb_first = o[0];
                    sck = m[1];
                    mo = pats[p] ^ 8'(m * 16 + o);
                    tx = {mo[3:0], mo[7:4]} ^ 8'h96;
                    tx_byte = tx;
                    wclk(4);
                    select(1'b0);
                    if (!cfg_cpha) chk("R12 first bit", {miso_oe, miso}, {1'b1, o[0] ? tx[0] : tx[7]});
                    xfer(mo, tx, 8, got);
                    chk("R2 R4 rx byte", rx_byte, mo);
                    chk("R3 R4 miso byte", got, tx);
                    chk("R5 done", done, 1);
                    chk("R10 oe selected", miso_oe, 1);
                    select(1'b1);
                    chk("R10 oe released", miso_oe, 0);
                    pulse_clr();
                    chk("R6 cleared", done, 0);
                end
            end
        end

        // R6 R7: back-to-back bytes, second overwrites while flag pending
        cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; sck = 0;
        tx_byte = 8'hC3; wclk(4);
        select(1'b0);
        xfer(8'h11, 8'h5E, 8, got);
        chk("R7 first rx", rx_byte, 8'h11); chk("R7 first miso", got, 8'hC3);
        wclk(10);
        chk("R6 flag held", done, 1);
        xfer(8'hE7, 8'h00, 8, got);
        chk("R7 overwrite rx", rx_byte, 8'hE7); chk("R7 reload miso", got, 8'h5E);
        chk("R7 flag still set", done, 1);
        select(1'b1); pulse_clr();

        // R8: abort after four bits, then an aligned full byte
        cfg_cpha = 1; cfg_cpol = 1; sck = 1; tx_byte = 8'h6B; wclk(4);
        select(1'b0);
        xfer(8'hF0, 8'h6B, 4, got);
        select(1'b1);
        sck = 1; wclk(4);
        chk("R8 no done after abort", done, 0);
        select(1'b0);
        xfer(8'h5A, 8'h6B, 8, got);
        chk("R8 aligned rx", rx_byte, 8'h5A); chk("R8 aligned miso", got, 8'h6B);
        select(1'b1); pulse_clr();

        // R9: activity with select high
        xfer(8'hAA, 8'h00, 8, got); xfer(8'h55, 8'h00, 8, got);
        chk("R9 passive done", done, 0); chk("R9 passive rx", rx_byte, 8'h5A);
        chk("R9 passive oe", miso_oe, 0);

        // R10: output drive disabled by configuration
        cfg_miso_en = 0; select(1'b0);
        chk("R10 oe off by cfg", miso_oe, 0);
        select(1'b1); cfg_miso_en = 1;

        // R11: block disabled
        cfg_en = 0; select(1'b0);
        chk("R11 oe disabled", miso_oe, 0);
        xfer(8'h99, 8'h00, 8, got);
        chk("R11 no done", done, 0); chk("R11 rx kept", rx_byte, 8'h5A);
        select(1'b1); cfg_en = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule